// File: doc/BRIEF.md
# Slow Clock Period Converter

This block turns the result of a slow-clock measurement into a fixed-point period. The inputs are the count of reference-clock cycles seen during the measurement, the number of slow-clock cycles the measurement spanned, and the reference frequency in MHz. From these it computes two results. The first is a rounded period: reference cycles per slow cycle per MHz, with `FRAC` fractional bits. The second is a raw ratio: reference cycles per slow cycle, with the same fractional scaling.

A source flag marks the slow clock as a 32.768 kHz crystal. When the flag is set, the count is first compared with the value such a crystal should give, within a narrow tolerance. A count that misses that window is reported as a zero result, and the divisions are not run. Every division goes through one shared restoring divider that produces one quotient bit per cycle. The caller pulses `start_i` and waits for the one-cycle `done_o`.

Top module: `slowclk_period_calc`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `period_o`, `ratio_o`, `zero_o`, `win_fail_o` and `div_err_o` are all 0.
- R2: A `start_i` pulse while idle makes `busy_o` 1 from the next cycle. `busy_o` stays 1 until the cycle in which `done_o` is 1 for exactly one cycle, and in that cycle `busy_o` is 0. A `start_i` received while busy is ignored.
- R3: `period_o` is the low `OUT_W` bits of ((raw << FRAC) + D/2 − 1) / D in 64-bit unsigned modular arithmetic, where D = ref_mhz × slow_cycles.
- R4: `ratio_o` is the low `OUT_W` bits of (raw << FRAC) / slow_cycles.
- R5: If `slow_cyc_i` or `ref_mhz_i` is 0, the block does not divide. It reports `div_err_o` = 1, `win_fail_o` = 0, `period_o` = 0 and `ratio_o` = 0.
- R6: With `xtal32k_i` = 1, the expected count E is (ref_mhz × 1000000 × slow_cycles) >> 15, and the tolerance T is E / 2000. A raw count with E − T ≤ raw ≤ E + T, both bounds included, gives the normal results of R3 and R4.
- R7: With `xtal32k_i` = 1 and a raw count outside that window, `win_fail_o` = 1, `period_o` = 0 and `ratio_o` = 0.
- R8: With `xtal32k_i` = 0, no window check is made, and any raw count gives the results of R3 and R4 with `win_fail_o` = 0.
- R9: `zero_o` is 1 exactly when the reported `period_o` is 0.
- R10: The result outputs change only in the cycle in which `done_o` is 1, and hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| raw_cnt_i | input | CNT_W | Reference cycles counted |
| slow_cyc_i | input | CYC_W | Slow cycles measured |
| ref_mhz_i | input | FREQ_W | Reference frequency in MHz |
| xtal32k_i | input | 1 | Slow source is a 32.768 kHz crystal |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| period_o | output | OUT_W | Rounded fixed-point period |
| ratio_o | output | OUT_W | Fixed-point reference/slow ratio |
| zero_o | output | 1 | Reported period is zero |
| win_fail_o | output | 1 | Crystal plausibility check failed |
| div_err_o | output | 1 | Zero divisor input |

## Verification
Directed crystal cases put the raw count exactly on E − T and E + T, and one count beyond each bound. These separate an inclusive window from an exclusive one, and catch an off-by-one tolerance. A case with a one-cycle divisor and a zero count forces the wrapped rounding term, so a rounding offset that is missing or saturated shows up. Zero slow cycles and zero frequency exercise the error path on their own. Random counts, frequencies and cycle numbers, with and without the crystal flag and with counts placed near the window, compare both quotients with a bench model, and a start pulse sent mid-run must leave the first result unchanged.

// File: rtl/calp_pkg.sv
package calp_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_EVAL,
    S_DELTA,
    S_WIN,
    S_RATIO,
    S_PERIOD,
    S_FINISH
  } calp_state_t;
endpackage

// File: rtl/calp_divider.sv
module calp_divider #(
  parameter int DIV_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [DIV_W-1:0] dividend,
  input  logic [DIV_W-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [DIV_W-1:0] quotient
);
  localparam int CW = $clog2(DIV_W);

  logic [DIV_W-1:0] rem_q, dvd_q, dvs_q, rem_nx;
  logic [CW-1:0]    cnt_q;
  logic [DIV_W:0]   trial, diff;
  logic             qbit;

  always_comb begin
    trial  = {rem_q, dvd_q[DIV_W-1]};
    diff   = trial - {1'b0, dvs_q};
    qbit   = (trial >= {1'b0, dvs_q});
    rem_nx = qbit ? diff[DIV_W-1:0] : trial[DIV_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      dvd_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        rem_q <= '0;
        dvd_q <= dividend;
        dvs_q <= divisor;
        cnt_q <= CW'(DIV_W - 1);
        busy  <= 1'b1;
      end else if (busy) begin
        rem_q <= rem_nx;
        dvd_q <= {dvd_q[DIV_W-2:0], qbit};
        if (cnt_q == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign quotient = dvd_q;
endmodule

// File: rtl/calp_window.sv
module calp_window #(
  parameter int CNT_W  = 32,
  parameter int CYC_W  = 32,
  parameter int FREQ_W = 8,
  parameter int DIV_W  = 64,
  parameter int XSHIFT = 15
) (
  input  logic [CNT_W-1:0]  raw,
  input  logic [CYC_W-1:0]  cycles,
  input  logic [FREQ_W-1:0] mhz,
  input  logic [DIV_W-1:0]  tol,
  output logic [DIV_W-1:0]  expected,
  output logic              in_window
);
  logic [DIV_W-1:0] prod, lo, hi, raw_w;

  always_comb begin
    prod      = DIV_W'(mhz) * DIV_W'(64'd1000000) * DIV_W'(cycles);
    expected  = prod >> XSHIFT;
    lo        = expected - tol;
    hi        = expected + tol;
    raw_w     = DIV_W'(raw);
    in_window = (raw_w >= lo) && (raw_w <= hi);
  end
endmodule

// File: rtl/slowclk_period_calc.sv
module slowclk_period_calc #(
  parameter int CNT_W   = 32,
  parameter int CYC_W   = 32,
  parameter int FREQ_W  = 8,
  parameter int OUT_W   = 32,
  parameter int FRAC    = 19,
  parameter int DIV_W   = 64,
  parameter int XSHIFT  = 15,
  parameter int TOL_DIV = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  raw_cnt_i,
  input  logic [CYC_W-1:0]  slow_cyc_i,
  input  logic [FREQ_W-1:0] ref_mhz_i,
  input  logic              xtal32k_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [OUT_W-1:0]  period_o,
  output logic [OUT_W-1:0]  ratio_o,
  output logic              zero_o,
  output logic              win_fail_o,
  output logic              div_err_o
);
  import calp_pkg::*;

  calp_state_t      st;
  logic [CNT_W-1:0]  raw_q;
  logic [CYC_W-1:0]  cyc_q;
  logic [FREQ_W-1:0] mhz_q;
  logic              xtal_q;
  logic [DIV_W-1:0]  delta_q, div_a, div_b;
  logic              div_go;
  logic [OUT_W-1:0]  res_per, res_rat;
  logic              res_wf, res_err;

  logic [DIV_W-1:0] expected, quot, scaled, prod, per_dvd;
  logic             in_win, div_busy, div_done;

  always_comb begin
    scaled  = DIV_W'(raw_q) << FRAC;
    prod    = DIV_W'(mhz_q) * DIV_W'(cyc_q);
    per_dvd = scaled + (prod >> 1) - DIV_W'(1);
  end

  calp_window #(
    .CNT_W(CNT_W), .CYC_W(CYC_W), .FREQ_W(FREQ_W), .DIV_W(DIV_W), .XSHIFT(XSHIFT)
  ) u_win (
    .raw(raw_q), .cycles(cyc_q), .mhz(mhz_q), .tol(delta_q),
    .expected(expected), .in_window(in_win)
  );

  calp_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .dividend(div_a), .divisor(div_b),
    .busy(div_busy), .done(div_done), .quotient(quot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      raw_q      <= '0;
      cyc_q      <= '0;
      mhz_q      <= '0;
      xtal_q     <= 1'b0;
      delta_q    <= '0;
      div_a      <= '0;
      div_b      <= '0;
      div_go     <= 1'b0;
      res_per    <= '0;
      res_rat    <= '0;
      res_wf     <= 1'b0;
      res_err    <= 1'b0;
      done_o     <= 1'b0;
      period_o   <= '0;
      ratio_o    <= '0;
      zero_o     <= 1'b0;
      win_fail_o <= 1'b0;
      div_err_o  <= 1'b0;
    end else begin
      div_go <= 1'b0;
      done_o <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start_i) begin
            raw_q  <= raw_cnt_i;
            cyc_q  <= slow_cyc_i;
            mhz_q  <= ref_mhz_i;
            xtal_q <= xtal32k_i;
            st     <= S_EVAL;
          end
        end
        S_EVAL: begin
          res_wf  <= 1'b0;
          res_err <= 1'b0;
          if (cyc_q == '0 || mhz_q == '0) begin
            res_per <= '0;
            res_rat <= '0;
            res_err <= 1'b1;
            st      <= S_FINISH;
          end else if (xtal_q) begin
            div_go <= 1'b1;
            div_a  <= expected;
            div_b  <= DIV_W'(TOL_DIV);
            st     <= S_DELTA;
          end else begin
            div_go <= 1'b1;
            div_a  <= scaled;
            div_b  <= DIV_W'(cyc_q);
            st     <= S_RATIO;
          end
        end
        S_DELTA: begin
          if (div_done) begin
            delta_q <= quot;
            st      <= S_WIN;
          end
        end
        S_WIN: begin
          if (in_win) begin
            div_go <= 1'b1;
            div_a  <= scaled;
            div_b  <= DIV_W'(cyc_q);
            st     <= S_RATIO;
          end else begin
            res_per <= '0;
            res_rat <= '0;
            res_wf  <= 1'b1;
            st      <= S_FINISH;
          end
        end
        S_RATIO: begin
          if (div_done) begin
            res_rat <= quot[OUT_W-1:0];
            div_go  <= 1'b1;
            div_a   <= per_dvd;
            div_b   <= prod;
            st      <= S_PERIOD;
          end
        end
        S_PERIOD: begin
          if (div_done) begin
            res_per <= quot[OUT_W-1:0];
            st      <= S_FINISH;
          end
        end
        S_FINISH: begin
          period_o   <= res_per;
          ratio_o    <= res_rat;
          zero_o     <= (res_per == '0);
          win_fail_o <= res_wf;
          div_err_o  <= res_err;
          done_o     <= 1'b1;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (st != S_IDLE) || div_busy;
endmodule

// File: rtl/calp_checker.sv
module calp_checker #(
  parameter int OUT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [OUT_W-1:0] period_o,
  input logic [OUT_W-1:0] ratio_o,
  input logic             zero_o,
  input logic             win_fail_o,
  input logic             div_err_o
);
  // R2: start while idle raises busy next cycle
  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);
  // R2: done is a single-cycle pulse with busy low
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  // R5: divisor error reports zeros
  p_err_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (done_o && div_err_o) |-> (period_o == '0 && ratio_o == '0 && !win_fail_o));
  // R7: window failure reports zeros
  p_win_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (done_o && win_fail_o) |-> (period_o == '0 && ratio_o == '0));
  // R9: zero flag follows period
  p_zero_flag_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (zero_o == (period_o == '0)));
  // R10: results move only with done
  p_hold_period_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(period_o) |-> done_o);
  p_hold_ratio_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(ratio_o) |-> done_o);
endmodule

bind slowclk_period_calc calp_checker #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .period_o(period_o), .ratio_o(ratio_o), .zero_o(zero_o),
  .win_fail_o(win_fail_o), .div_err_o(div_err_o)
);

// File: tb/slowclk_period_calc_tb.sv
module slowclk_period_calc_tb;
  localparam int FRAC = 19;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] raw_cnt_i = '0;
  logic [31:0] slow_cyc_i = '0;
  logic [7:0]  ref_mhz_i = '0;
  logic        xtal32k_i = 1'b0;
  logic        busy_o, done_o, zero_o, win_fail_o, div_err_o;
  logic [31:0] period_o, ratio_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  slowclk_period_calc #(.FRAC(FRAC)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .raw_cnt_i(raw_cnt_i),
    .slow_cyc_i(slow_cyc_i), .ref_mhz_i(ref_mhz_i), .xtal32k_i(xtal32k_i),
    .busy_o(busy_o), .done_o(done_o), .period_o(period_o), .ratio_o(ratio_o),
    .zero_o(zero_o), .win_fail_o(win_fail_o), .div_err_o(div_err_o)
  );

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint unsigned exp_cnt(input int unsigned mhz, input int unsigned cyc);
    longint unsigned p;
    p = longint'(mhz) * 64'd1000000 * longint'(cyc);
    return p >> 15;
  endfunction

  task automatic model(input int unsigned raw, input int unsigned cyc, input int unsigned mhz,
                       input bit xt, output int unsigned per, output int unsigned rat,
                       output bit wf, output bit er);
    longint unsigned e, t, d, s, q;
    per = 0; rat = 0; wf = 0; er = 0;
    if (cyc == 0 || mhz == 0) begin
      er = 1;
      return;
    end
    if (xt) begin
      e = exp_cnt(mhz, cyc);
      t = e / 2000;
      if (longint'(raw) < e - t || longint'(raw) > e + t) begin
        wf = 1;
        return;
      end
    end
    s   = longint'(raw) << FRAC;
    q   = s / longint'(cyc);
    rat = q[31:0];
    d   = longint'(mhz) * longint'(cyc);
    q   = (s + (d >> 1) - 64'd1) / d;
    per = q[31:0];
  endtask

  task automatic run(input int unsigned raw, input int unsigned cyc, input int unsigned mhz,
                     input bit xt, input bit poke);
    int unsigned per, rat;
    bit wf, er;
    int n;
    model(raw, cyc, mhz, xt, per, rat, wf, er);
    @(negedge clk);
    raw_cnt_i = raw; slow_cyc_i = cyc; ref_mhz_i = mhz[7:0]; xtal32k_i = xt;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 busy after start", busy_o, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      raw_cnt_i = ~raw; slow_cyc_i = cyc + 7; ref_mhz_i = 8'd3; xtal32k_i = 1'b0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    n = 0;
    while (!done_o && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk("R2 done seen", done_o, 1);
    chk("R2 busy low at done", busy_o, 0);
    chk("R3 period", period_o, per);
    chk("R4 ratio", ratio_o, rat);
    chk("R5 div_err", div_err_o, er);
    chk(xt ? "R6 R7 win_fail" : "R8 win_fail", win_fail_o, wf);
    chk("R9 zero flag", zero_o, per == 0);
    @(negedge clk);
    chk("R2 done one cycle", done_o, 0);
    chk("R10 period held", period_o, per);
    chk("R10 ratio held", ratio_o, rat);
  endtask

  initial begin
    repeat (10000000) @(negedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed, raw, cyc, mhz;
    longint unsigned e, t;
    bit xt;
    seed = 32'h5eed1234;
    void'($urandom(seed));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 period", period_o, 0);
    chk("R1 ratio", ratio_o, 0);
    chk("R1 flags", {zero_o, win_fail_o, div_err_o}, 0);

    // R6 and R7: window edges, E=1250000, T=625
    run(32'd1250000 + 625, 1024, 40, 1, 0);
    run(32'd1250000 - 625, 1024, 40, 1, 0);
    run(32'd1250000 + 626, 1024, 40, 1, 0);
    run(32'd1250000 - 626, 1024, 40, 1, 0);
    run(32'd1250000, 1024, 40, 1, 0);
    // R8: same count out of window, flag clear
    run(32'd5, 1024, 40, 0, 0);
    // R5: zero divisor inputs
    run(32'd1000, 0, 40, 0, 0);
    run(32'd1000, 16, 0, 1, 0);
    // R3: wrapped rounding term with D=1, raw=0
    run(32'd0, 1, 1, 0, 0);
    // R9: period rounds to zero
    run(32'd0, 8, 20, 0, 0);
    // R2: start while busy ignored
    run(32'd123456, 100, 26, 0, 1);
    run(32'd1250000, 1024, 40, 1, 1);
    // random mix
    for (int i = 0; i < 150; i++) begin
      cyc = 1 + ($urandom % 4096);
      mhz = 1 + ($urandom % 80);
      xt  = $urandom % 2;
      if (xt) begin
        e   = exp_cnt(mhz, cyc);
        t   = e / 2000;
        raw = 32'(e + 1 - t - 2 + longint'($urandom % (2 * t + 4)));
      end else begin
        raw = $urandom;
      end
      run(raw, cyc, mhz, xt, (i % 10) == 3);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule